// File: doc/BRIEF.md
# Audio Master and Bit Clock Generator

This block turns a single fast port clock into the three clocks an audio serial port needs. The first is a master clock for the external codec, given as a one-cycle enable. The second is the bit clock. The third is the left/right frame clock. The port clock runs at one of two fixed multiples of the sample rate, 512 or 384. A base-select input tells the generator which multiple it is receiving, and all of its arithmetic is derived from that choice.

A 3-bit code divides the port clock by a power of two to form the master clock. A separate width input picks 32 or 48 bit-clock periods per frame. The 48-period setting is the one needed for 20-bit and 24-bit samples. In slave mode the bit and frame clocks come from another port, so this generator holds its own copies of those clocks low.

The frame is built on a phase counter that counts port cycles from 0 to one below the frame length. Once the generator is running, settings move into effect only when that counter wraps. A change made in the middle of a frame therefore never cuts a clock pulse short.

Top module: `acg_clock_gen`

## Requirements
- R1: While reset is held, `mclk_en`, `bclk` and `fclk` are all low.
- R2: A clock edge sampled with `run` low drives all three outputs low and puts the phase back to 0. The k-th consecutive edge with `run` high then yields phase p = k mod L. L is 512 when `base_alt` is 0 and 384 when it is 1. Every output below is a function of p and the settings in effect.
- R3: With `base_alt`=0 and `mult_code` c in 0..4, `mclk_en` is high exactly when p is a multiple of 2^c. This gives a master clock of 512/2^c times the sample rate.
- R4: With `base_alt`=1 and `mult_code` c in 0..3, `mclk_en` is high exactly when p is a multiple of 2^c. This gives 384/2^c times the sample rate.
- R5: A code with no valid ratio keeps `mclk_en` low. The invalid codes are 5..7 when `base_alt`=0 and 4..7 when `base_alt`=1.
- R6: `bclk` is high when floor(p·2N/L) is odd. N is 32 when `wide_bclk` is 0 and 48 when it is 1, so each frame holds N bit-clock periods.
- R7: `fclk` is low for p < L/2 and high for p ≥ L/2. This is one period per frame, toggling every N/2 bit clocks.
- R8: While `slave_mode` is high, `bclk` and `fclk` stay low and `mclk_en` behaves as in R3 to R5.
- R9: While running, a change to `base_alt`, `mult_code` or `wide_bclk` takes effect only at the edge where the phase wraps to 0. From that edge on, the new frame length applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_port | input | 1 | Port clock, 512 or 384 times the sample rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Enables all clock generation |
| base_alt | input | 1 | 0: port clock is 512·fs, 1: port clock is 384·fs |
| mult_code | input | 3 | Master clock divide code, divides by 2^code |
| wide_bclk | input | 1 | 0: 32 bit clocks per frame, 1: 48 bit clocks per frame |
| slave_mode | input | 1 | Bit and frame clocks are supplied externally |
| mclk_en | output | 1 | Master clock enable, one port cycle per master period |
| bclk | output | 1 | Bit clock level |
| fclk | output | 1 | Frame (left/right) clock level |

## Verification
The bench builds the block with its default ratios: 512 and 384 for the port clock, 32 and 48 for the bit clock, and 32 as the smallest master ratio. It sweeps all eight codes under both bases and both bit-clock widths, over two frames each. That covers every valid divider, every invalid code, and the uneven spacing of a 48-period bit clock against a 512-cycle frame. Separate runs switch the base in mid-frame to show the change waiting for the wrap, stop and restart the port mid-frame, and run with slave mode set.

// File: rtl/acg_pkg.sv
package acg_pkg;
  localparam int ACG_CODE_W = 3;

  typedef struct packed {
    logic                  base_alt;
    logic                  wide;
    logic [ACG_CODE_W-1:0] code;
  } acg_cfg_t;

  // A divide code is usable when it divides the ratio evenly and leaves
  // a master clock no slower than the minimum ratio.
  function automatic logic code_valid(input logic [31:0] ratio,
                                      input logic [31:0] code,
                                      input logic [31:0] min_ratio);
    logic [31:0] q;
    q = ratio >> code;
    return (q >= min_ratio) && ((q << code) == ratio);
  endfunction

  function automatic logic mclk_hit(input logic [31:0] pos,
                                    input logic [31:0] code);
    return (pos & ((32'd1 << code) - 32'd1)) == 32'd0;
  endfunction

  // Level of a clock with `edges` level changes spread evenly over `ratio` cycles
  function automatic logic spread_level(input logic [31:0] pos,
                                        input logic [31:0] edges,
                                        input logic [31:0] ratio);
    logic [31:0] idx;
    idx = (pos * edges) / ratio;
    return idx[0];
  endfunction
endpackage

// File: rtl/acg_cfg_shadow.sv
module acg_cfg_shadow
  import acg_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     run,
  input  logic     wrap,
  input  acg_cfg_t cfg_in,
  output acg_cfg_t cfg_q,
  output acg_cfg_t cfg_next
);
  logic load;
  assign load     = !run || wrap;
  assign cfg_next = load ? cfg_in : cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_next;
  end
endmodule

// File: rtl/acg_frame_ctr.sv
module acg_frame_ctr #(
  parameter int RATIO_STD = 512,
  parameter int RATIO_ALT = 384,
  parameter int POS_W     = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             base_alt,
  output logic [POS_W-1:0] pos_q,
  output logic [POS_W-1:0] pos_next,
  output logic             wrap
);
  logic [POS_W-1:0] last_pos;
  assign last_pos = base_alt ? POS_W'(RATIO_ALT - 1) : POS_W'(RATIO_STD - 1);
  assign wrap     = run && (pos_q == last_pos);

  always_comb begin
    if (!run || wrap) pos_next = '0;
    else              pos_next = pos_q + POS_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= '0;
    else        pos_q <= pos_next;
  end
endmodule

// File: rtl/acg_clk_decode.sv
module acg_clk_decode
  import acg_pkg::*;
#(
  parameter int RATIO_STD = 512,
  parameter int RATIO_ALT = 384,
  parameter int BITS_STD  = 32,
  parameter int BITS_WIDE = 48,
  parameter int MCLK_MIN  = 32,
  parameter int POS_W     = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             slave_mode,
  input  logic [POS_W-1:0] pos_next,
  input  acg_cfg_t         cfg_next,
  output logic             mclk_en,
  output logic             bclk,
  output logic             fclk
);
  localparam logic [31:0] EDGES_STD  = 32'(2 * BITS_STD);
  localparam logic [31:0] EDGES_WIDE = 32'(2 * BITS_WIDE);

  logic [31:0] p, edges, code;
  logic        ok_std, ok_alt, code_ok;
  logic        lvl_std, lvl_alt;
  logic        upper;
  logic        mclk_d, bclk_d, fclk_d;

  assign p     = 32'(pos_next);
  assign code  = 32'(cfg_next.code);
  assign edges = cfg_next.wide ? EDGES_WIDE : EDGES_STD;

  // both ratios are evaluated against constants, then selected
  assign ok_std  = code_valid(32'(RATIO_STD), code, 32'(MCLK_MIN));
  assign ok_alt  = code_valid(32'(RATIO_ALT), code, 32'(MCLK_MIN));
  assign lvl_std = spread_level(p, edges, 32'(RATIO_STD));
  assign lvl_alt = spread_level(p, edges, 32'(RATIO_ALT));
  assign code_ok = cfg_next.base_alt ? ok_alt : ok_std;
  assign upper   = cfg_next.base_alt ? (p >= 32'(RATIO_ALT / 2))
                                     : (p >= 32'(RATIO_STD / 2));

  assign mclk_d = run && code_ok && mclk_hit(p, code);
  assign bclk_d = run && !slave_mode && (cfg_next.base_alt ? lvl_alt : lvl_std);
  assign fclk_d = run && !slave_mode && upper;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mclk_en <= 1'b0;
      bclk    <= 1'b0;
      fclk    <= 1'b0;
    end else begin
      mclk_en <= mclk_d;
      bclk    <= bclk_d;
      fclk    <= fclk_d;
    end
  end
endmodule

// File: rtl/acg_clock_gen.sv
module acg_clock_gen
  import acg_pkg::*;
#(
  parameter int RATIO_STD = 512,
  parameter int RATIO_ALT = 384,
  parameter int BITS_STD  = 32,
  parameter int BITS_WIDE = 48,
  parameter int MCLK_MIN  = 32
) (
  input  logic                  clk_port,
  input  logic                  rst_n,
  input  logic                  run,
  input  logic                  base_alt,
  input  logic [ACG_CODE_W-1:0] mult_code,
  input  logic                  wide_bclk,
  input  logic                  slave_mode,
  output logic                  mclk_en,
  output logic                  bclk,
  output logic                  fclk
);
  localparam int RATIO_MAX = (RATIO_STD > RATIO_ALT) ? RATIO_STD : RATIO_ALT;
  localparam int POS_W     = $clog2(RATIO_MAX);

  acg_cfg_t         cfg_in, cfg_q, cfg_next;
  logic [POS_W-1:0] pos_q, pos_next;
  logic             frame_wrap;

  // observation points for the checker
  logic             cfg_code_ok;
  logic [POS_W-1:0] half_len;

  assign cfg_in      = '{base_alt: base_alt, wide: wide_bclk, code: mult_code};
  assign cfg_code_ok = cfg_q.base_alt
                     ? code_valid(32'(RATIO_ALT), 32'(cfg_q.code), 32'(MCLK_MIN))
                     : code_valid(32'(RATIO_STD), 32'(cfg_q.code), 32'(MCLK_MIN));
  assign half_len    = cfg_q.base_alt ? POS_W'(RATIO_ALT / 2) : POS_W'(RATIO_STD / 2);

  acg_cfg_shadow u_shadow (
    .clk      (clk_port),
    .rst_n    (rst_n),
    .run      (run),
    .wrap     (frame_wrap),
    .cfg_in   (cfg_in),
    .cfg_q    (cfg_q),
    .cfg_next (cfg_next)
  );

  acg_frame_ctr #(
    .RATIO_STD (RATIO_STD),
    .RATIO_ALT (RATIO_ALT),
    .POS_W     (POS_W)
  ) u_frame (
    .clk      (clk_port),
    .rst_n    (rst_n),
    .run      (run),
    .base_alt (cfg_q.base_alt),
    .pos_q    (pos_q),
    .pos_next (pos_next),
    .wrap     (frame_wrap)
  );

  acg_clk_decode #(
    .RATIO_STD (RATIO_STD),
    .RATIO_ALT (RATIO_ALT),
    .BITS_STD  (BITS_STD),
    .BITS_WIDE (BITS_WIDE),
    .MCLK_MIN  (MCLK_MIN),
    .POS_W     (POS_W)
  ) u_decode (
    .clk        (clk_port),
    .rst_n      (rst_n),
    .run        (run),
    .slave_mode (slave_mode),
    .pos_next   (pos_next),
    .cfg_next   (cfg_next),
    .mclk_en    (mclk_en),
    .bclk       (bclk),
    .fclk       (fclk)
  );
endmodule

// File: rtl/acg_clock_gen_chk.sv
module acg_clock_gen_chk
  import acg_pkg::*;
#(
  parameter int POS_W = 9
) (
  input logic             clk_port,
  input logic             rst_n,
  input logic             run,
  input logic             slave_mode,
  input logic             mclk_en,
  input logic             bclk,
  input logic             fclk,
  input logic [POS_W-1:0] pos_q,
  input logic [POS_W-1:0] half_len,
  input acg_cfg_t         cfg_q,
  input logic             frame_wrap,
  input logic             cfg_code_ok
);
  AST_IDLE_QUIET: assert property (@(posedge clk_port) disable iff (!rst_n)
    !run |=> (!mclk_en && !bclk && !fclk)); // R2

  AST_MCLK_ALIGN: assert property (@(posedge clk_port) disable iff (!rst_n)
    mclk_en |-> ((32'(pos_q) & ((32'd1 << cfg_q.code) - 32'd1)) == 32'd0)); // R3

  AST_BAD_CODE_SILENT: assert property (@(posedge clk_port) disable iff (!rst_n)
    !cfg_code_ok |-> !mclk_en); // R5

  AST_FRAME_HALF: assert property (@(posedge clk_port) disable iff (!rst_n)
    fclk |-> (pos_q >= half_len)); // R7

  AST_SLAVE_QUIET: assert property (@(posedge clk_port) disable iff (!rst_n)
    slave_mode |=> (!bclk && !fclk)); // R8

  AST_CFG_HOLD: assert property (@(posedge clk_port) disable iff (!rst_n)
    (run && !frame_wrap) |=> $stable(cfg_q)); // R9
endmodule

bind acg_clock_gen acg_clock_gen_chk #(.POS_W(POS_W)) u_chk (
  .clk_port    (clk_port),
  .rst_n       (rst_n),
  .run         (run),
  .slave_mode  (slave_mode),
  .mclk_en     (mclk_en),
  .bclk        (bclk),
  .fclk        (fclk),
  .pos_q       (pos_q),
  .half_len    (half_len),
  .cfg_q       (cfg_q),
  .frame_wrap  (frame_wrap),
  .cfg_code_ok (cfg_code_ok)
);

// File: tb/acg_clock_gen_test.sv
module acg_clock_gen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run = 1'b0;
  logic       base_alt = 1'b0;
  logic [2:0] mult_code = 3'd0;
  logic       wide_bclk = 1'b0;
  logic       slave_mode = 1'b0;
  logic       mclk_en, bclk, fclk;

  int  n_total = 0;
  int  n_bad   = 0;
  bit  finished = 1'b0;

  always #5 clk = ~clk;

  acg_clock_gen uut (
    .clk_port   (clk),
    .rst_n      (rst_n),
    .run        (run),
    .base_alt   (base_alt),
    .mult_code  (mult_code),
    .wide_bclk  (wide_bclk),
    .slave_mode (slave_mode),
    .mclk_en    (mclk_en),
    .bclk       (bclk),
    .fclk       (fclk)
  );

  function automatic int flen(bit b);
    return b ? 384 : 512;
  endfunction

  function automatic bit code_usable(bit b, int c);
    return b ? (c <= 3) : (c <= 4);
  endfunction

  function automatic bit want_mclk(bit b, int c, int p);
    return code_usable(b, c) && ((p % (1 << c)) == 0);
  endfunction

  function automatic bit want_bclk(bit b, bit w, bit s, int p);
    int nb;
    nb = w ? 48 : 32;
    if (s) return 1'b0;
    return (((p * 2 * nb) / flen(b)) % 2) == 1;
  endfunction

  function automatic bit want_fclk(bit b, bit s, int p);
    if (s) return 1'b0;
    return p >= flen(b) / 2;
  endfunction

  task automatic chk(input logic act, input logic exp, input string tag, input int p);
    n_total++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s phase=%0d actual=%b expected=%b", tag, p, act, exp);
    end
  endtask

  task automatic check_point(input int p, input bit b, input int c, input bit w,
                             input bit s, input string force_tag);
    string mt, bt, ft;
    mt = !code_usable(b, c) ? "R5" : (b ? "R4" : "R3");
    bt = s ? "R8" : "R6";
    ft = s ? "R8" : "R7";
    if (force_tag != "") begin mt = force_tag; bt = force_tag; ft = force_tag; end
    chk(mclk_en, want_mclk(b, c, p), {mt, " mclk_en"}, p);
    chk(bclk, want_bclk(b, w, s, p), {bt, " bclk"}, p);
    chk(fclk, want_fclk(b, s, p), {ft, " fclk"}, p);
  endtask

  task automatic run_cfg(input bit b, input int c, input bit w, input bit s, input int ncyc);
    @(negedge clk);
    run = 1'b0; base_alt = b; mult_code = 3'(c); wide_bclk = w; slave_mode = s;
    @(negedge clk);
    run = 1'b1;
    for (int i = 1; i <= ncyc; i++) begin
      @(negedge clk);
      check_point(i % flen(b), b, c, w, s, "");
    end
    run = 1'b0;
  endtask

  initial begin
    // R1: reset state
    @(negedge clk); @(negedge clk);
    chk(mclk_en, 1'b0, "R1 mclk_en", 0);
    chk(bclk, 1'b0, "R1 bclk", 0);
    chk(fclk, 1'b0, "R1 fclk", 0);
    rst_n = 1'b1;

    // R3 R4 R5 R6 R7: sweep of every base, code and width
    for (int b = 0; b < 2; b++)
      for (int c = 0; c < 8; c++)
        for (int w = 0; w < 2; w++)
          run_cfg(b[0], c, w[0], 1'b0, 2 * flen(b[0]));

    // R8: slave mode keeps bit and frame clocks low
    run_cfg(1'b0, 2, 1'b1, 1'b1, 512);
    run_cfg(1'b1, 0, 1'b0, 1'b1, 384);

    // R2: stop mid-frame, then restart from phase 0
    @(negedge clk);
    run = 1'b0; base_alt = 1'b0; mult_code = 3'd1; wide_bclk = 1'b0; slave_mode = 1'b0;
    @(negedge clk);
    run = 1'b1;
    for (int i = 1; i <= 300; i++) @(negedge clk);
    check_point(300, 1'b0, 1, 1'b0, 1'b0, "R2");
    run = 1'b0;
    @(negedge clk);
    chk(mclk_en, 1'b0, "R2 idle mclk_en", 0);
    chk(bclk, 1'b0, "R2 idle bclk", 0);
    chk(fclk, 1'b0, "R2 idle fclk", 0);
    run = 1'b1;
    for (int i = 1; i <= 40; i++) begin
      @(negedge clk);
      check_point(i, 1'b0, 1, 1'b0, 1'b0, "R2");
    end

    // R9: settings changed mid-frame wait for the wrap
    @(negedge clk);
    run = 1'b0; base_alt = 1'b0; mult_code = 3'd1; wide_bclk = 1'b0;
    @(negedge clk);
    run = 1'b1;
    for (int i = 1; i <= 512 + 384 + 20; i++) begin
      @(negedge clk);
      if (i < 512) check_point(i, 1'b0, 1, 1'b0, 1'b0, "R9");
      else         check_point((i - 512) % 384, 1'b1, 2, 1'b1, 1'b0, "R9");
      if (i == 100) begin base_alt = 1'b1; mult_code = 3'd2; wide_bclk = 1'b1; end
    end
    run = 1'b0;
    @(negedge clk);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", n_total, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_total++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", n_total, n_bad);
      $finish;
    end
  end
endmodule